// File: doc/BRIEF.md
# Interleaved Cache Line Fill Controller

This controller services one cache miss at a time by fetching a whole line from a memory that is split into word-interleaved banks. All banks sit behind one narrow shared bus. When a miss is accepted, the controller sends one address beat to each bank on back-to-back cycles, starting with bank 0. All banks then run their accesses in parallel. The data words come back on consecutive cycles in bank order, and the controller places each word into its slot of the line. With the default shape of four 64-bit banks and an 8-cycle bank access, the fill takes 1 + 8 + 4 = 13 bus cycles. Serving the same line one word at a time would take 4 × (1 + 8 + 1) = 40 cycles.

The block is built around a four-state machine:
- **IDLE**: ready for a miss.
- **ISSUE**: sending the address beats.
- **COLLECT**: waiting for the remaining data words.
- **DONE**: a single cycle that presents the finished line.

The transitions are:
- **accept**: IDLE to ISSUE, when a request is taken.
- **beats_sent**: ISSUE to COLLECT, after the beat for the last bank.
- **line_full**: COLLECT to DONE, when the last word is captured.
- **release**: DONE to IDLE, unconditionally.

A synchronous reset from any state is the **abort** transition back to IDLE.

Top module: `line_fill_ctrl`

## Requirements
- R1: While reset is asserted and in the cycle after it, `miss_ready` is 1, `line_valid` is 0, `bus_addr_valid` is 0 and `line_data` is all zeros.
- R2: When `miss_valid` and `miss_ready` are both 1 at a clock edge, `bus_addr_valid` is 1 in each of the next NUM_BANKS cycles. In beat k (k = 0, 1, 2, …), `bus_addr` equals the captured line address in its upper bits and k in its low log2(NUM_BANKS) bits. After the last beat, `bus_addr_valid` returns to 0.
- R3: `miss_ready` is 0 from the cycle after acceptance through the `line_valid` cycle. A request held during that window produces no extra address beats.
- R4: The i-th word seen with `bus_data_valid` during a fill is the word of bank i. It is stored at bits [WORD_W·i +: WORD_W] of `line_data`.
- R5: `line_valid` is 1 for exactly one cycle: the cycle after the last data word is captured. With 8-cycle banks and the first address beat in cycle c, `line_valid` is high in cycle c + 13.
- R6: `miss_ready` is 1 again in the cycle after `line_valid`, so a request held high is accepted at that edge and its first address beat follows in the next cycle.
- R7: While no fill is running, `bus_data_valid` has no effect: `line_data` keeps its value and `line_valid` stays 0.
- R8: A reset during a fill drops the partial line. `line_data` becomes zero, no `line_valid` follows, data returning afterwards is ignored, and the next fill assembles correctly from bank 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| miss_valid | input | 1 | Miss request present |
| miss_ready | output | 1 | Controller can take a miss request |
| miss_line_addr | input | LINE_ADDR_W | Line address of the miss |
| bus_addr_valid | output | 1 | Address beat on the bus this cycle |
| bus_addr | output | LINE_ADDR_W+log2(NUM_BANKS) | Word address; the low bits select the bank |
| bus_data_valid | input | 1 | Data word on the bus this cycle |
| bus_data | input | WORD_W | Returning data word |
| line_valid | output | 1 | One-cycle pulse: `line_data` holds the complete line |
| line_data | output | NUM_BANKS·WORD_W | Assembled line; the word of bank k is at offset WORD_W·k |

## Verification
The bench builds the controller with its defaults: four banks, 64-bit words and a 26-bit line address. It pairs them with bank responders that answer 8 cycles after each address beat. This parameter set makes the 13-cycle schedule visible cycle by cycle. It also covers every bank-index value in the low address bits and the all-zero and all-one line addresses. The default responder latency keeps all four accesses in flight at once, which is exactly the overlap whose timing is under test.

// File: rtl/lfc_pkg.sv
`timescale 1ns/1ps
package lfc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_COLLECT,
        ST_DONE
    } fill_state_e;
endpackage

// File: rtl/lfc_beat_gen.sv
`timescale 1ns/1ps
// Holds the line address of the current miss and steps the bank index
// once per address beat.
module lfc_beat_gen #(
    parameter int NUM_BANKS   = 4,
    parameter int LINE_ADDR_W = 26
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   load,
    input  logic [LINE_ADDR_W-1:0]                 line_addr_in,
    input  logic                                   issue_en,
    output logic                                   beat_valid,
    output logic [LINE_ADDR_W+$clog2(NUM_BANKS)-1:0] beat_addr,
    output logic                                   last_beat
);
    localparam int IDX_W = $clog2(NUM_BANKS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BANKS - 1);

    logic [LINE_ADDR_W-1:0] line_q;
    logic [IDX_W-1:0]       idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= '0;
            idx_q  <= '0;
        end else if (load) begin
            line_q <= line_addr_in;
            idx_q  <= '0;
        end else if (issue_en) begin
            if (idx_q == LAST_IDX) begin
                idx_q <= '0;
            end else begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    assign beat_valid = issue_en;
    assign beat_addr  = {line_q, idx_q};
    assign last_beat  = issue_en && (idx_q == LAST_IDX);
endmodule

// File: rtl/lfc_line_asm.sv
`timescale 1ns/1ps
// Steers each returning word into the slot selected by the receive count.
module lfc_line_asm #(
    parameter int NUM_BANKS = 4,
    parameter int WORD_W    = 64
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          take_en,
    input  logic                          word_valid,
    input  logic [WORD_W-1:0]             word_in,
    output logic [NUM_BANKS*WORD_W-1:0]   line_out,
    output logic                          last_word
);
    localparam int IDX_W = $clog2(NUM_BANKS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BANKS - 1);

    logic [IDX_W-1:0] cnt_q;
    logic             capture;

    assign capture   = take_en && word_valid;
    assign last_word = capture && (cnt_q == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (capture) begin
            if (cnt_q == LAST_IDX) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + IDX_W'(1);
            end
        end
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_slot
        logic [WORD_W-1:0] word_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (capture && (cnt_q == IDX_W'(g))) begin
                word_q <= word_in;
            end
        end

        assign line_out[g*WORD_W +: WORD_W] = word_q;
    end
endmodule

// File: rtl/line_fill_ctrl.sv
`timescale 1ns/1ps
module line_fill_ctrl #(
    parameter int NUM_BANKS   = 4,
    parameter int WORD_W      = 64,
    parameter int LINE_ADDR_W = 26
) (
    input  logic                                     clk,
    input  logic                                     rst,
    input  logic                                     miss_valid,
    output logic                                     miss_ready,
    input  logic [LINE_ADDR_W-1:0]                   miss_line_addr,
    output logic                                     bus_addr_valid,
    output logic [LINE_ADDR_W+$clog2(NUM_BANKS)-1:0] bus_addr,
    input  logic                                     bus_data_valid,
    input  logic [WORD_W-1:0]                        bus_data,
    output logic                                     line_valid,
    output logic [NUM_BANKS*WORD_W-1:0]              line_data
);
    import lfc_pkg::*;

    fill_state_e state_q, state_d;
    logic        accept;
    logic        issue_en;
    logic        take_en;
    logic        last_beat;
    logic        last_word;

    assign accept = miss_valid && miss_ready;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: accept, beats_sent, line_full, release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (accept)    state_d = ST_ISSUE;
            ST_ISSUE:   if (last_beat) state_d = ST_COLLECT;
            ST_COLLECT: if (last_word) state_d = ST_DONE;
            ST_DONE:                   state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // Outputs per state
    always_comb begin
        miss_ready = 1'b0;
        issue_en   = 1'b0;
        take_en    = 1'b0;
        line_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:    miss_ready = 1'b1;
            ST_ISSUE: begin
                issue_en = 1'b1;
                take_en  = 1'b1;
            end
            ST_COLLECT: take_en    = 1'b1;
            ST_DONE:    line_valid = 1'b1;
            default:    miss_ready = 1'b0;
        endcase
    end

    lfc_beat_gen #(
        .NUM_BANKS   (NUM_BANKS),
        .LINE_ADDR_W (LINE_ADDR_W)
    ) u_beat_gen (
        .clk          (clk),
        .rst          (rst),
        .load         (accept),
        .line_addr_in (miss_line_addr),
        .issue_en     (issue_en),
        .beat_valid   (bus_addr_valid),
        .beat_addr    (bus_addr),
        .last_beat    (last_beat)
    );

    lfc_line_asm #(
        .NUM_BANKS (NUM_BANKS),
        .WORD_W    (WORD_W)
    ) u_line_asm (
        .clk        (clk),
        .rst        (rst),
        .take_en    (take_en),
        .word_valid (bus_data_valid),
        .word_in    (bus_data),
        .line_out   (line_data),
        .last_word  (last_word)
    );
endmodule

// File: rtl/lfc_chk.sv
`timescale 1ns/1ps
module lfc_chk #(
    parameter int NUM_BANKS   = 4,
    parameter int WORD_W      = 64,
    parameter int LINE_ADDR_W = 26
) (
    input logic                                     clk,
    input logic                                     rst,
    input logic                                     miss_valid,
    input logic                                     miss_ready,
    input logic [LINE_ADDR_W-1:0]                   miss_line_addr,
    input logic                                     bus_addr_valid,
    input logic [LINE_ADDR_W+$clog2(NUM_BANKS)-1:0] bus_addr,
    input logic                                     bus_data_valid,
    input logic                                     line_valid,
    input logic [NUM_BANKS*WORD_W-1:0]              line_data
);
    localparam int IDX_W = $clog2(NUM_BANKS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BANKS - 1);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (miss_ready && !line_valid && !bus_addr_valid && (line_data == '0)));

    // R2
    first_beat_chk: assert property (@(posedge clk) disable iff (rst)
        (miss_valid && miss_ready) |=>
            (bus_addr_valid && (bus_addr[IDX_W-1:0] == '0)
             && (bus_addr[LINE_ADDR_W+IDX_W-1:IDX_W] == $past(miss_line_addr))));

    // R2
    beat_step_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr_valid && (bus_addr[IDX_W-1:0] != LAST_IDX)) |=>
            (bus_addr_valid && (bus_addr[IDX_W-1:0] == $past(bus_addr[IDX_W-1:0]) + IDX_W'(1))));

    // R2
    beat_end_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr_valid && (bus_addr[IDX_W-1:0] == LAST_IDX)) |=> !bus_addr_valid);

    // R3
    busy_no_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr_valid || line_valid) |-> !miss_ready);

    // R5
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        line_valid |=> !line_valid);

    // R5
    pulse_after_word_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(line_valid) |-> $past(bus_data_valid));

    // R6
    ready_after_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        line_valid |=> miss_ready);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        miss_ready |=> $stable(line_data));
endmodule

bind line_fill_ctrl lfc_chk #(
    .NUM_BANKS   (NUM_BANKS),
    .WORD_W      (WORD_W),
    .LINE_ADDR_W (LINE_ADDR_W)
) i_lfc_chk (
    .clk            (clk),
    .rst            (rst),
    .miss_valid     (miss_valid),
    .miss_ready     (miss_ready),
    .miss_line_addr (miss_line_addr),
    .bus_addr_valid (bus_addr_valid),
    .bus_addr       (bus_addr),
    .bus_data_valid (bus_data_valid),
    .line_valid     (line_valid),
    .line_data      (line_data)
);

// File: tb/test_line_fill_ctrl.sv
`timescale 1ns/1ps
module test_line_fill_ctrl;
    localparam int NB  = 4;
    localparam int WW  = 64;
    localparam int LAW = 26;
    localparam int IW  = 2;
    localparam int WAW = LAW + IW;
    localparam int LAT = 8;
    localparam int LW  = NB * WW;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           miss_valid = 1'b0;
    logic           miss_ready;
    logic [LAW-1:0] miss_line_addr = '0;
    logic           bus_addr_valid;
    logic [WAW-1:0] bus_addr;
    logic           bus_data_valid;
    logic [WW-1:0]  bus_data;
    logic           line_valid;
    logic [LW-1:0]  line_data;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    line_fill_ctrl #(.NUM_BANKS(NB), .WORD_W(WW), .LINE_ADDR_W(LAW)) i_line_fill_ctrl (
        .clk            (clk),
        .rst            (rst),
        .miss_valid     (miss_valid),
        .miss_ready     (miss_ready),
        .miss_line_addr (miss_line_addr),
        .bus_addr_valid (bus_addr_valid),
        .bus_addr       (bus_addr),
        .bus_data_valid (bus_data_valid),
        .bus_data       (bus_data),
        .line_valid     (line_valid),
        .line_data      (line_data)
    );

    function automatic logic [WW-1:0] word_of(input logic [WAW-1:0] wa);
        return {4'h5, wa, wa * 32'h9E37_79B1};
    endfunction

    function automatic logic [LW-1:0] exp_line(input logic [LAW-1:0] la);
        logic [LW-1:0] r;
        for (int k = 0; k < NB; k++) r[k*WW +: WW] = word_of({la, IW'(k)});
        return r;
    endfunction

    // Bank responders: answer LAT cycles after each address beat.
    logic [LAT:0]          pv = '0;
    logic [LAT:0][WAW-1:0] pa = '0;
    logic                  rsp_v = 1'b0;
    logic [WW-1:0]         rsp_d = '0;
    logic                  stray_v = 1'b0;
    logic [WW-1:0]         stray_d = '0;

    always @(negedge clk) begin
        rsp_v <= pv[LAT];
        rsp_d <= word_of(pa[LAT]);
        for (int i = LAT; i > 0; i--) begin
            pv[i] <= pv[i-1];
            pa[i] <= pa[i-1];
        end
        pv[0] <= bus_addr_valid;
        pa[0] <= bus_addr;
    end

    assign bus_data_valid = rsp_v | stray_v;
    assign bus_data       = rsp_v ? rsp_d : stray_d;

    task automatic chk(input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge of cycle 15 after acceptance.
    task automatic do_fill(input logic [LAW-1:0] la, input bit hold, input logic [LAW-1:0] nxt);
        miss_valid     = 1'b1;
        miss_line_addr = la;
        chk("R6 ready before accept", LW'(miss_ready), LW'(1));
        @(posedge clk);
        for (int c = 1; c <= 15; c++) begin
            @(negedge clk);
            if (c == 1) begin
                miss_valid     = hold;
                miss_line_addr = nxt;
            end
            if (c <= NB) begin
                chk("R2 beat valid", LW'(bus_addr_valid), LW'(1));
                chk("R2 beat address", LW'(bus_addr), LW'({la, IW'(c - 1)}));
            end else begin
                chk("R3 no extra beat", LW'(bus_addr_valid), LW'(0));
            end
            if (c <= 14) chk("R3 busy", LW'(miss_ready), LW'(0));
            else         chk("R6 ready after pulse", LW'(miss_ready), LW'(1));
            chk("R5 line_valid timing", LW'(line_valid), LW'(c == 14));
            if (c == 14) chk("R4 assembled line", line_data, exp_line(la));
        end
    endtask

    task automatic idle(input int n, input logic [LW-1:0] held);
        miss_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            stray_v = 1'($urandom);
            stray_d = {$urandom, $urandom};
            @(negedge clk);
            chk("R7 no pulse when idle", LW'(line_valid), LW'(0));
            chk("R7 line held when idle", line_data, held);
        end
        stray_v = 1'b0;
    endtask

    initial begin
        logic [LAW-1:0] la;
        logic [LAW-1:0] nx;
        void'($urandom(32'd20240611));
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 reset ready", LW'(miss_ready), LW'(1));
        chk("R1 reset pulse", LW'(line_valid), LW'(0));
        chk("R1 reset beat", LW'(bus_addr_valid), LW'(0));
        chk("R1 reset line", line_data, '0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset ready", LW'(miss_ready), LW'(1));

        idle(4, '0);
        do_fill('0, 1'b0, '0);
        idle(3, exp_line('0));
        do_fill('1, 1'b1, 26'h155_5555);
        do_fill(26'h155_5555, 1'b0, '0);
        idle(2, exp_line(26'h155_5555));

        for (int t = 0; t < 24; t++) begin
            la = LAW'($urandom);
            nx = LAW'($urandom);
            if ($urandom % 2 == 0) begin
                do_fill(la, 1'b1, nx);
                do_fill(nx, 1'b0, '0);
                idle(1 + $urandom % 3, exp_line(nx));
            end else begin
                do_fill(la, 1'b0, '0);
                idle(1 + $urandom % 3, exp_line(la));
            end
        end

        // R8: reset in the middle of a fill
        miss_valid     = 1'b1;
        miss_line_addr = 26'h2AB_CDEF;
        @(posedge clk);
        @(negedge clk);
        miss_valid = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R8 partial line dropped", line_data, '0);
        chk("R8 ready after abort", LW'(miss_ready), LW'(1));
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            chk("R8 no pulse after abort", LW'(line_valid), LW'(0));
            chk("R8 late data ignored", line_data, '0);
        end
        la = LAW'($urandom);
        do_fill(la, 1'b0, '0);
        idle(2, exp_line(la));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule